// File: doc/BRIEF.md
# Down-Counting Interval Timer

A 32-bit interval timer that sits on a simple word-wide register bus. Software programs a reload value and a control word; once running, the timer counts down by one on every cycle where the `tick` input is high. When the count reaches zero and the enable bit is set, the interrupt output rises. On the following running tick the count is refilled from the reload register, so the zero value is held for exactly one tick before the next interval begins.

A single control bit does two jobs. It enables the interrupt and it also enables the automatic refill. With that bit clear, the timer runs down to zero and stays there with the interrupt low. The interrupt is a level signal computed from the stored state only, so it does not depend on the run bit. A free scratch register is also provided, and the hardware never touches it.

Bus accesses complete in the cycle they are presented: read data and the error pulse are valid in that same cycle, and writes take effect at the next clock edge. Any access that is not a full-word access to a mapped, writable word raises the error output and changes nothing.

Top module: `ivt_timer`

## Requirements
- R1: After reset the scratch, control, reload and count registers read zero and `irq` is low.
- R2: Word offsets are fixed as follows. 0x0 is the scratch register (read/write), 0x4 is control (read/write), 0x8 is reload (read/write) and 0xC is the current count (read only). Bus words are big-endian: `bus_wdata[31:24]`/`bus_rdata[31:24]` is lane 0 (enabled by `bus_be[3]`) and holds the most significant byte.
- R3: Control bit 2 is the run bit. On a clock edge with `tick` high, run set and a nonzero count, the count drops by exactly one.
- R4: On a clock edge with `tick` high, run set and a count of zero, the count loads the reload value if control bit 0 is set. If bit 0 is clear, the count stays at zero.
- R5: `irq` is high exactly when the count is zero and control bit 0 is set, whatever the run bit holds.
- R6: When `tick` is low or the run bit is clear, the count keeps its value.
- R7: An access is invalid if `bus_be` is not 4'b1111, the address is not word aligned, the offset is unmapped, or it is a write to 0xC. An invalid access raises `bus_err` in that cycle, leaves every register unchanged, and returns 0 on `bus_rdata`.
- R8: The scratch register changes only through a legal bus write to offset 0x0.
- R9: Writing the reload register does not change the count. The new value is first used at the next refill.
- R10: A control write that sets the run bit takes effect on ticks after the write's clock edge. A tick in the same cycle as the write still sees the old control value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable; one decrement per high cycle while running |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (4) | Byte address inside the timer |
| bus_be | input | 4 | Byte lane enables; bit 3 is lane 0 (MSB) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data; 0 unless a legal read is presented |
| bus_err | output | 1 | Invalid access pulse |
| irq | output | 1 | Level interrupt |

## Verification
A count register that slips or skips shows up at the next read of offset 0xC, and also as `irq` rising one tick early or late against the programmed interval. A refill taken from the wrong source is visible on the first read after the zero tick. A bad decode shows in the same cycle as the access, either as a wrong `bus_err` or as nonzero read data. A write that leaks through on an invalid access is exposed by reading the targeted register back on the very next access.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam logic [1:0] SEL_SCRATCH = 2'd0;
  localparam logic [1:0] SEL_CTRL    = 2'd1;
  localparam logic [1:0] SEL_RELOAD  = 2'd2;
  localparam logic [1:0] SEL_COUNT   = 2'd3;
  localparam int CTRL_IEN_BIT = 0;
  localparam int CTRL_RUN_BIT = 2;
endpackage

// File: rtl/ivt_regs.sv
module ivt_regs
  import ivt_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_valid,
  input  logic            bus_write,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW/8-1:0] bus_be,
  input  logic [DW-1:0]   bus_wdata,
  input  logic [DW-1:0]   count_i,
  output logic [DW-1:0]   bus_rdata,
  output logic            bus_err,
  output logic            run_o,
  output logic            ien_o,
  output logic [DW-1:0]   reload_o
);
  logic [DW-1:0] scratch_q, scratch_d;
  logic [DW-1:0] ctrl_q,    ctrl_d;
  logic [DW-1:0] reload_q,  reload_d;
  logic          hi_zero;
  logic          aligned, full_word, legal;
  logic [1:0]    sel;

  generate
    if (AW > 4) begin : g_hi
      assign hi_zero = ~|bus_addr[AW-1:4];
    end else begin : g_nohi
      assign hi_zero = 1'b1;
    end
  endgenerate

  assign sel       = bus_addr[3:2];
  assign aligned   = (bus_addr[1:0] == 2'b00);
  assign full_word = &bus_be;
  assign legal     = bus_valid && full_word && aligned && hi_zero &&
                     !(bus_write && sel == SEL_COUNT);
  assign bus_err   = bus_valid && !legal;

  always_comb begin
    scratch_d = scratch_q;
    ctrl_d    = ctrl_q;
    reload_d  = reload_q;
    if (legal && bus_write) begin
      unique case (sel)
        SEL_SCRATCH: scratch_d = bus_wdata;
        SEL_CTRL:    ctrl_d    = bus_wdata;
        SEL_RELOAD:  reload_d  = bus_wdata;
        default:     ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (legal && !bus_write) begin
      unique case (sel)
        SEL_SCRATCH: bus_rdata = scratch_q;
        SEL_CTRL:    bus_rdata = ctrl_q;
        SEL_RELOAD:  bus_rdata = reload_q;
        default:     bus_rdata = count_i;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scratch_q <= '0;
      ctrl_q    <= '0;
      reload_q  <= '0;
    end else begin
      scratch_q <= scratch_d;
      ctrl_q    <= ctrl_d;
      reload_q  <= reload_d;
    end
  end

  assign run_o    = ctrl_q[CTRL_RUN_BIT];
  assign ien_o    = ctrl_q[CTRL_IEN_BIT];
  assign reload_o = reload_q;
endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          run,
  input  logic          refill_en,
  input  logic [DW-1:0] reload,
  output logic [DW-1:0] count_o
);
  logic [DW-1:0] count_q, count_d;
  logic          step;

  assign step = tick && run;

  always_comb begin
    count_d = count_q;
    if (step) begin
      if (count_q != '0)  count_d = count_q - 1'b1;
      else if (refill_en) count_d = reload;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  assign count_o = count_q;
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            bus_valid,
  input  logic            bus_write,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW/8-1:0] bus_be,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            bus_err,
  output logic            irq
);
  logic [DW-1:0] count_w;
  logic [DW-1:0] reload_w;
  logic          run_w;
  logic          ien_w;

  ivt_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .count_i   (count_w),
    .bus_rdata (bus_rdata),
    .bus_err   (bus_err),
    .run_o     (run_w),
    .ien_o     (ien_w),
    .reload_o  (reload_w)
  );

  ivt_counter #(.DW(DW)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .run       (run_w),
    .refill_en (ien_w),
    .reload    (reload_w),
    .count_o   (count_w)
  );

  assign irq = (count_w == '0) && ien_w;
endmodule

// File: rtl/ivt_timer_chk.sv
module ivt_timer_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          bus_valid,
  input logic          bus_err,
  input logic [DW-1:0] bus_rdata,
  input logic          irq,
  input logic          run,
  input logic          ien,
  input logic [DW-1:0] count,
  input logic [DW-1:0] reload
);
  // R3
  a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && count != '0) |=> (count == $past(count) - 1'b1));

  // R4
  a_r4_refill: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && count == '0 && ien) |=> (count == $past(reload)));

  // R5
  a_r5_irq_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && ien && count == 1 && !bus_valid) |=> irq);

  // R6
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && run) |=> $stable(count));

  // R7
  a_r7_err_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> ($stable(reload) && $stable(run) && $stable(ien)));

  // R7
  a_r7_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_rdata == '0));
endmodule

bind ivt_timer ivt_timer_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .bus_valid (bus_valid),
  .bus_err   (bus_err),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .run       (run_w),
  .ien       (ien_w),
  .count     (count_w),
  .reload    (reload_w)
);

// File: tb/ivt_timer_tb.sv
module ivt_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic        irq;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ivt_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .irq(irq)
  );

  // {write, addr, be, wdata, exp_rdata, exp_err, req}
  localparam int NV = 17;
  localparam logic [77:0] VEC [NV] = '{
    {1'b0, 4'h0, 4'hF, 32'h0,         32'h0,         1'b0, 4'd1}, // R1
    {1'b0, 4'h4, 4'hF, 32'h0,         32'h0,         1'b0, 4'd1}, // R1
    {1'b0, 4'h8, 4'hF, 32'h0,         32'h0,         1'b0, 4'd1}, // R1
    {1'b0, 4'hC, 4'hF, 32'h0,         32'h0,         1'b0, 4'd1}, // R1
    {1'b1, 4'h0, 4'hF, 32'hA5A5_0001, 32'h0,         1'b0, 4'd2}, // R2
    {1'b1, 4'h8, 4'hF, 32'h0000_0010, 32'h0,         1'b0, 4'd2}, // R2
    {1'b0, 4'h0, 4'hF, 32'h0,         32'hA5A5_0001, 1'b0, 4'd2}, // R2
    {1'b0, 4'h8, 4'hF, 32'h0,         32'h0000_0010, 1'b0, 4'd2}, // R2
    {1'b1, 4'h4, 4'h7, 32'h5,         32'h0,         1'b1, 4'd7}, // R7
    {1'b0, 4'h4, 4'hF, 32'h0,         32'h0,         1'b0, 4'd7}, // R7
    {1'b1, 4'hC, 4'hF, 32'h1234,      32'h0,         1'b1, 4'd7}, // R7
    {1'b0, 4'hC, 4'hF, 32'h0,         32'h0,         1'b0, 4'd7}, // R7
    {1'b1, 4'h2, 4'hF, 32'hFFFF_FFFF, 32'h0,         1'b1, 4'd7}, // R7
    {1'b0, 4'h6, 4'hF, 32'h0,         32'h0,         1'b1, 4'd7}, // R7
    {1'b0, 4'h0, 4'h3, 32'h0,         32'h0,         1'b1, 4'd7}, // R7
    {1'b1, 4'h8, 4'h0, 32'hFF,        32'h0,         1'b1, 4'd7}, // R7
    {1'b0, 4'h8, 4'hF, 32'h0,         32'h0000_0010, 1'b0, 4'd7}  // R7
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Drive at a negedge, sample 1 ns later, release at the next negedge.
  task automatic access(input bit wr, input logic [3:0] a, input logic [3:0] be,
                        input logic [31:0] d, output logic [31:0] rd,
                        output logic er);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_be = be; bus_wdata = d;
    #1;
    rd = bus_rdata; er = bus_err;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    logic [31:0] rd; logic er;
    access(1'b1, a, 4'hF, d, rd, er);
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] rd; logic er;
    access(1'b0, a, 4'hF, 32'h0, rd, er);
    check(req, $sformatf("read %h", a), rd, exp);
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    for (int i = 0; i < n; i++) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic irq_chk(input string req, input logic exp);
    #1;
    check(req, "irq", {31'b0, irq}, {31'b0, exp});
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd; logic er;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    irq_chk("R1", 1'b0);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][77], VEC[i][76:73], VEC[i][72:69], VEC[i][68:37], rd, er);
      check($sformatf("R%0d", VEC[i][3:0]), $sformatf("vec %0d rdata", i),
            rd, VEC[i][36:5]);
      check($sformatf("R%0d", VEC[i][3:0]), $sformatf("vec %0d err", i),
            {31'b0, er}, {31'b0, VEC[i][4]});
    end

    // R5: enable alone, count at zero, run clear -> irq high
    wr(4'h8, 32'd3);
    irq_chk("R5", 1'b0);
    wr(4'h4, 32'h1);
    irq_chk("R5", 1'b1);
    // R10: tick in the same cycle as the run-setting write sees old control
    tick = 1'b1;
    wr(4'h4, 32'h5);
    tick = 1'b0;
    rd_chk("R10", 4'hC, 32'd0);
    // R4: zero on a running tick with bit 0 set -> refill
    ticks(1);
    rd_chk("R4", 4'hC, 32'd3);
    irq_chk("R5", 1'b0);
    // R3: decrement per tick
    ticks(2);
    rd_chk("R3", 4'hC, 32'd1);
    ticks(1);
    irq_chk("R5", 1'b1);
    // R9: reload write leaves count alone
    wr(4'h8, 32'd7);
    rd_chk("R9", 4'hC, 32'd0);
    ticks(1);
    rd_chk("R9", 4'hC, 32'd7);
    // R6: run clear freezes count
    wr(4'h4, 32'h1);
    ticks(3);
    rd_chk("R6", 4'hC, 32'd7);
    // R6: run set but tick low
    wr(4'h4, 32'h4);
    repeat (4) @(negedge clk);
    rd_chk("R6", 4'hC, 32'd7);
    // R4: bit 0 clear -> stays at zero, no irq
    ticks(9);
    rd_chk("R4", 4'hC, 32'd0);
    irq_chk("R4", 1'b0);
    // R5: irq independent of run bit
    wr(4'h4, 32'h1);
    irq_chk("R5", 1'b1);
    // R8: scratch untouched by all of the above
    rd_chk("R8", 4'h0, 32'hA5A5_0001);
    // R7: rejected write to count while running
    wr(4'h4, 32'h4);
    access(1'b1, 4'hC, 4'hF, 32'hDEAD, rd, er);
    check("R7", "err on count write", {31'b0, er}, 32'h1);
    rd_chk("R7", 4'hC, 32'd0);
    // R1: reset clears everything again
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd_chk("R1", 4'h0, 32'h0);
    rd_chk("R1", 4'h4, 32'h0);
    rd_chk("R1", 4'h8, 32'h0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule